// File: doc/BRIEF.md
# Read Data Parity Status Checker

This block watches the data bus of a processor bus interface during read cycles and checks the per-byte parity bits that come back with the data. When a read cycle completes, the block captures the data, the parity bits and the byte-lane qualifiers on that clock edge. In the following clock it drives an active-low status output that goes low only if a checked lane carried bad parity. In every other clock the output sits high.

Which lanes count depends on two inputs: the byte enables of the cycle and the width of the bus the current device reports (full 32-bit, 16-bit or 8-bit). Writes never raise an error. A test-mode input releases the output enable so that the pin can be floated. The output is driven at all other times.

Top module: `rd_parity_status`

## Requirements
- R1: Parity is even per byte lane. Lane i covers `rd_data[8i+7:8i]` together with `rd_par[i]`. A checked lane whose nine bits hold an odd number of ones is a parity error.
- R2: When `rdy_n` is low and `wr_not_rd` is low at a rising clock edge, `par_stat_n` is low for exactly the following clock if any checked lane had a parity error. It is high for that clock otherwise.
- R3: A cycle with `wr_not_rd` high (a write) never drives `par_stat_n` low, whatever the data, parity and `rdy_n`.
- R4: With both `narrow8_n` and `narrow16_n` high (full width), lane i is checked exactly when `lane_en_n[i]` is low. With no lane enabled, no error is reported.
- R5: With `narrow16_n` low and `narrow8_n` high (16-bit width), only lanes 0 and 1 are checked, each only when its own `lane_en_n` bit is low. Errors on lanes 2 and 3 are ignored.
- R6: With `narrow8_n` low (8-bit width, which takes priority over `narrow16_n`), only lane 0 is checked. It is checked whenever at least one `lane_en_n` bit is low, and lanes 1 to 3 are ignored.
- R7: `par_stat_oe` is low while `tristate_test` is high and high otherwise. The status value itself is not affected by test mode.
- R8: While `rst_n` is low, `par_stat_n` is high immediately, without waiting for a clock edge. After `rst_n` rises, a completing read is only captured from the third rising edge on.
- R9: A clock edge with `rdy_n` high leaves `par_stat_n` high in the next clock, whatever the data and parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rd_data | input | 32 | Read data bus, four byte lanes |
| rd_par | input | 4 | Parity bit per byte lane |
| lane_en_n | input | 4 | Active-low byte enables of the current cycle |
| narrow8_n | input | 1 | Active-low: the device is 8 bits wide |
| narrow16_n | input | 1 | Active-low: the device is 16 bits wide |
| rdy_n | input | 1 | Active-low ready, ends the cycle |
| wr_not_rd | input | 1 | 1 = write cycle, 0 = read cycle |
| tristate_test | input | 1 | Test mode that releases the status output |
| par_stat_n | output | 1 | Active-low parity status |
| par_stat_oe | output | 1 | Output enable for the status pin |

## Verification
The bench targets lane qualification at each bus width:
- An error placed on a disabled lane, or on a lane that the 16-bit or 8-bit width excludes, must leave the status high. A design that ignores the width or the enables would pull it low.
- With 8-bit width it also places an error on lane 0 while lane 0 itself is disabled but another lane is enabled. A design that treats lane 0 like a full-width lane would miss that error.

The bench also covers timing:
- Back-to-back erroneous reads, and an idle clock right after an error, expose a status that is stretched, latched or shifted by one clock.
- A write with bad data and ready low exposes a block that does not look at the direction.
- A reset asserted while a pulse is showing exposes a reset that is not asynchronous.

// File: rtl/rps_pkg.sv
`timescale 1ns/1ps
package rps_pkg;
  typedef enum logic [1:0] {
    BW_FULL = 2'd0,
    BW_HALF = 2'd1,
    BW_BYTE = 2'd2
  } bus_width_e;

  function automatic bus_width_e decode_width(input logic n8, input logic n16);
    if (!n8)       return BW_BYTE;
    else if (!n16) return BW_HALF;
    else           return BW_FULL;
  endfunction
endpackage

// File: rtl/rps_reset_sync.sv
`timescale 1ns/1ps
module rps_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/rps_lane_select.sv
`timescale 1ns/1ps
module rps_lane_select
  import rps_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] lane_en_n,
  input  bus_width_e       width,
  output logic [LANES-1:0] chk_mask
);
  localparam int HALF = (LANES >= 2) ? LANES / 2 : 1;

  logic [LANES-1:0] en;
  logic [LANES-1:0] half_keep;

  assign en = ~lane_en_n;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_half
      assign half_keep[g] = (g < HALF);
    end
  endgenerate

  always_comb begin
    chk_mask = '0;
    unique case (width)
      BW_BYTE: chk_mask[0] = |en;
      BW_HALF: chk_mask    = en & half_keep;
      default: chk_mask    = en;
    endcase
  end
endmodule

// File: rtl/rps_lane_parity.sv
`timescale 1ns/1ps
module rps_lane_parity #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] data,
  input  logic [LANES-1:0]        par,
  input  logic [LANES-1:0]        chk_mask,
  output logic                    any_bad
);
  logic [LANES-1:0] lane_bad;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic odd;
      assign odd         = ^{data[g*LANE_W +: LANE_W], par[g]};
      assign lane_bad[g] = chk_mask[g] & odd;
    end
  endgenerate

  assign any_bad = |lane_bad;
endmodule

// File: rtl/rps_status_reg.sv
`timescale 1ns/1ps
module rps_status_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic err_in,
  output logic status_n
);
  logic pulse_q;
  logic pulse_d;

  always_comb begin
    pulse_d = 1'b0;
    if (capture) pulse_d = err_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign status_n = ~pulse_q;
endmodule

// File: rtl/rd_parity_status.sv
`timescale 1ns/1ps
module rd_parity_status
  import rps_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] rd_data,
  input  logic [LANES-1:0]        rd_par,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic                    narrow8_n,
  input  logic                    narrow16_n,
  input  logic                    rdy_n,
  input  logic                    wr_not_rd,
  input  logic                    tristate_test,
  output logic                    par_stat_n,
  output logic                    par_stat_oe
);
  logic             rst_n_int;
  bus_width_e       width;
  logic [LANES-1:0] chk_mask;
  logic             any_bad;
  logic             rd_done;
  logic             stat_n_int;

  rps_reset_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  assign width   = decode_width(narrow8_n, narrow16_n);
  assign rd_done = ~rdy_n & ~wr_not_rd;

  rps_lane_select #(.LANES(LANES)) u_sel (
    .lane_en_n (lane_en_n),
    .width     (width),
    .chk_mask  (chk_mask)
  );

  rps_lane_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_par (
    .data     (rd_data),
    .par      (rd_par),
    .chk_mask (chk_mask),
    .any_bad  (any_bad)
  );

  rps_status_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .capture  (rd_done),
    .err_in   (any_bad),
    .status_n (stat_n_int)
  );

  assign par_stat_n  = stat_n_int;
  assign par_stat_oe = ~tristate_test;
endmodule

// File: rtl/rps_checker.sv
`timescale 1ns/1ps
module rps_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] lane_en_n,
  input logic             rdy_n,
  input logic             wr_not_rd,
  input logic             tristate_test,
  input logic             par_stat_n,
  input logic             par_stat_oe
);
  // R2, R9: a low status needs a completing cycle one clock earlier
  a_r2_follows_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !par_stat_n |-> $past(!rdy_n));

  // R3: writes never cause an error pulse
  a_r3_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !par_stat_n |-> $past(!wr_not_rd));

  // R4: with no lane enabled nothing is checked
  a_r4_no_lane_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !par_stat_n |-> $past(lane_en_n != '1));

  // R7: output released only in test mode
  a_r7_oe_test: assert property (@(posedge clk) disable iff (!rst_n)
    !par_stat_oe |-> tristate_test);

  // R8: reset holds the status inactive
  a_r8_reset_high: assert property (@(posedge clk)
    !rst_n |=> par_stat_n);
endmodule

bind rd_parity_status rps_checker #(.LANES(LANES)) u_rps_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .lane_en_n     (lane_en_n),
  .rdy_n         (rdy_n),
  .wr_not_rd     (wr_not_rd),
  .tristate_test (tristate_test),
  .par_stat_n    (par_stat_n),
  .par_stat_oe   (par_stat_oe)
);

// File: tb/rd_parity_status_bench.sv
`timescale 1ns/1ps
module rd_parity_status_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] rd_data;
  logic [3:0]  rd_par;
  logic [3:0]  lane_en_n;
  logic        narrow8_n, narrow16_n, rdy_n, wr_not_rd, tristate_test;
  logic        par_stat_n, par_stat_oe;

  int    n_cmp  = 0;
  int    n_bad  = 0;
  logic  exp_stat;
  string pend_tag;

  rd_parity_status u_rd_parity_status (
    .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .rd_par(rd_par),
    .lane_en_n(lane_en_n), .narrow8_n(narrow8_n), .narrow16_n(narrow16_n),
    .rdy_n(rdy_n), .wr_not_rd(wr_not_rd), .tristate_test(tristate_test),
    .par_stat_n(par_stat_n), .par_stat_oe(par_stat_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [3:0] good_par(input logic [31:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ^d[i*8 +: 8];
    return p;
  endfunction

  // reference: does the captured cycle report an error?
  function automatic logic model_err(input logic [31:0] d, input logic [3:0] p,
                                     input logic [3:0] be_n, input logic n8, input logic n16);
    logic bad;
    bad = 1'b0;
    for (int i = 0; i < 4; i++) begin
      logic chk;
      if (!n8)       chk = (i == 0) && (be_n != 4'hF);
      else if (!n16) chk = (i < 2) && !be_n[i];
      else           chk = !be_n[i];
      if (chk && ((($countones(d[i*8 +: 8]) + int'(p[i])) % 2) == 1)) bad = 1'b1;
    end
    return bad;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [31:0] d, input logic [3:0] p, input logic [3:0] be_n,
                      input logic n8, input logic n16, input logic rdy, input logic wr,
                      input logic tt, input string tag);
    @(negedge clk);
    check({pend_tag, " status"}, par_stat_n, exp_stat);
    rd_data = d; rd_par = p; lane_en_n = be_n; narrow8_n = n8; narrow16_n = n16;
    rdy_n = rdy; wr_not_rd = wr; tristate_test = tt;
    #1;
    check("R7 oe", par_stat_oe, !tt);
    exp_stat = (!rdy && !wr) ? !model_err(d, p, be_n, n8, n16) : 1'b1;
    pend_tag = tag;
  endtask

  task automatic idle(input string tag);
    step(32'h0, 4'h0, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    check("R8 async", par_stat_n, 1'b1);
    exp_stat = 1'b1;
    pend_tag = "R8 reset";
    idle("R8 reset");
    idle("R8 reset");
    @(negedge clk);
    rst_n = 1'b1;
    exp_stat = 1'b1;
    for (int i = 0; i < 4; i++) idle("R8 after release");
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; rd_data = '0; rd_par = '0; lane_en_n = 4'hF;
    narrow8_n = 1'b1; narrow16_n = 1'b1; rdy_n = 1'b1; wr_not_rd = 1'b0;
    tristate_test = 1'b0; exp_stat = 1'b1; pend_tag = "R8 init";
    do_reset();

    d = 32'hA5C3_1E77;
    // R1 R4 full width
    step(d, good_par(d),           4'h0, 1, 1, 0, 0, 0, "R1 good all lanes");
    step(d, good_par(d) ^ 4'b0100, 4'h0, 1, 1, 0, 0, 0, "R1 bad lane2");
    idle("R2 one clock only");
    step(d, good_par(d) ^ 4'b0001, 4'h0, 1, 1, 0, 0, 0, "R2 back to back a");
    step(d, good_par(d) ^ 4'b1000, 4'h0, 1, 1, 0, 0, 0, "R2 back to back b");
    step(d, good_par(d) ^ 4'b1000, 4'h0, 1, 1, 1, 0, 0, "R9 not ready");
    step(d, good_par(d) ^ 4'b1111, 4'h0, 1, 1, 0, 1, 0, "R3 write");
    step(d, good_par(d) ^ 4'b1000, 4'b1000, 1, 1, 0, 0, 0, "R4 disabled lane3");
    step(d, good_par(d) ^ 4'b1111, 4'hF, 1, 1, 0, 0, 0, "R4 no lanes");
    // R5 16-bit
    step(d, good_par(d) ^ 4'b0100, 4'h0, 1, 0, 0, 0, 0, "R5 lane2 ignored");
    step(d, good_par(d) ^ 4'b0010, 4'b1100, 1, 0, 0, 0, 0, "R5 lane1 bad");
    step(d, good_par(d) ^ 4'b0010, 4'b1110, 1, 0, 0, 0, 0, "R5 lane1 disabled");
    // R6 8-bit, priority over 16-bit
    step(d, good_par(d) ^ 4'b0010, 4'h0, 0, 0, 0, 0, 0, "R6 lane1 ignored");
    step(d, good_par(d) ^ 4'b0001, 4'b1011, 0, 1, 0, 0, 0, "R6 lane0 via lane2 enable");
    step(d, good_par(d) ^ 4'b0001, 4'hF, 0, 0, 0, 0, 0, "R6 nothing enabled");
    // R7 test mode
    step(d, good_par(d) ^ 4'b0001, 4'h0, 1, 1, 0, 0, 1, "R7 test mode status");
    idle("R7 exit");
    // R8 reset during a pulse
    step(d, good_par(d) ^ 4'b0001, 4'h0, 1, 1, 0, 0, 0, "R8 pre reset");
    @(negedge clk);
    check("R8 pulse before reset", par_stat_n, exp_stat);
    rdy_n = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R8 async clear", par_stat_n, 1'b1);
    exp_stat = 1'b1; pend_tag = "R8 held";
    idle("R8 held");
    @(negedge clk);
    rst_n = 1'b1;
    exp_stat = 1'b1;
    // R8 no capture during the synchroniser delay
    step(d, good_par(d) ^ 4'b0001, 4'h0, 1, 1, 0, 0, 0, "R8 sync edge1");
    exp_stat = 1'b1;
    idle("R8 sync idle");
    idle("R8 sync idle");
    // random mix, R1 R2 R3 R4 R5 R6 R9
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rd;
      logic [3:0]  fl;
      rd = $urandom;
      fl = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
      step(rd, good_par(rd) ^ fl, 4'($urandom), ($urandom % 4) != 0, ($urandom % 3) != 0,
           ($urandom % 3) == 0, ($urandom % 5) == 0, ($urandom % 9) == 0, "R1 random");
    end
    idle("R2 drain");
    @(negedge clk);
    check({pend_tag, " status"}, par_stat_n, exp_stat);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule